// File: doc/BRIEF.md
# Resistive Cell Forming Sequencer

This block drives the one-time forming procedure of a pristine resistive memory cell. After a start command it applies a series of programming pulses, each described by an amplitude code and a timed enable, and after every pulse it asks for a read of the cell's resistance. The procedure ends as soon as a read comes back below a programmable threshold (success), or when the strongest and longest pulse has been applied and the cell still reads at or above the threshold (failure).

The pulse schedule sweeps two dimensions. Within one amplitude level the pulse width starts at a base value and doubles each step until it reaches a cap of `CAP_MULT` times the base, where it is clamped. Once the capped width has been tried, the amplitude code rises by `V_STEP` and the width restarts at the base. The amplitude never passes the configured upper code. With the default codes (one step per 0.1 V) a sweep runs from 40 to 90 and a base width of 100 µs gives widths of base, 2x, 4x, 8x and 10x. Every cell goes through the same schedule; the cell index is only latched and presented on `cell_sel` for the analogue side.

The read path is two valid/ready channels. The request channel (`rd_valid`/`rd_ready`) carries no data; once raised, `rd_valid` stays high until the cycle in which `rd_ready` is seen, so the reader may stall it for any number of cycles. The result channel (`res_valid`/`res_ready`/`res_data`) is accepted only while `res_ready` is high; `res_ready` is raised only after the request has been taken, and a result offered at any other time is not consumed. Start and the configuration inputs are plain control pins.

Top module: `cell_form_ctrl`

## Requirements
- R1: After reset `busy`, `pulse_en`, `rd_valid`, `res_ready`, `form_pass` and `form_fail` are all 0.
- R2: A start seen while idle latches threshold, upper amplitude code, base width and cell index (shown on `cell_sel`) and raises `busy` on the next cycle; a start while busy, and any change of the configuration inputs after the accepted start, has no effect on the running schedule.
- R3: Pulse widths within one amplitude level are base, then each previous width doubled, clamped to base times `CAP_MULT`; the pulse after the clamped width is again of base width. A base width of 0 is treated as 1.
- R4: The first pulse uses the smaller of the first and upper amplitude codes; each level rises by `V_STEP` and is clamped to the upper code, which `pulse_code` never exceeds while busy.
- R5: `pulse_en` stays high for exactly the scheduled width in cycles, and `pulse_code` is constant while it is high.
- R6: `rd_valid` rises only after `pulse_en` has been low for at least one full cycle, and it stays high until `rd_ready` is seen.
- R7: `res_ready` is high only while a result is awaited and never together with `pulse_en`; the next pulse begins only after a result has been accepted.
- R8: An accepted result strictly below the threshold ends the procedure with `form_pass` = 1; a result equal to the threshold does not.
- R9: An accepted result at or above the threshold after the last pulse (upper code, capped width) ends the procedure with `form_fail` = 1.
- R10: `form_pass` and `form_fail` are never both 1, are cleared by an accepted start and hold their value, with `busy` low, until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin forming (taken only while idle) |
| cell_idx | input | IDX_W | Index of the cell to form |
| cfg_thresh | input | RES_W | Success threshold (pass when result is below it) |
| cfg_v_first | input | CODE_W | Amplitude code of the first level |
| cfg_v_last | input | CODE_W | Highest amplitude code |
| cfg_base_width | input | WID_W | First pulse width in cycles |
| pulse_code | output | CODE_W | Amplitude code of the current pulse |
| pulse_en | output | 1 | Pulse active |
| cell_sel | output | IDX_W | Latched cell index |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| res_valid | input | 1 | Resistance result valid |
| res_ready | output | 1 | Result accepted |
| res_data | input | RES_W | Resistance result |
| busy | output | 1 | Procedure running |
| form_pass | output | 1 | Cell formed |
| form_fail | output | 1 | Schedule exhausted without forming |

## Verification
The assertions take for granted that the first amplitude code is not above the upper code plus nothing beyond it, that the capped width fits in the width counter, and that the reader neither withdraws `rd_ready` expectations nor relies on a result being taken outside the `res_ready` window. The stimulus keeps to this by using small codes and base widths, by stalling the read request for a varying number of cycles, and by offering each result only while `res_ready` is high. Every run places the passing read at a different pulse index, including none, so the whole schedule of two small configurations is walked.

// File: rtl/cell_form_pkg.sv
`timescale 1ns/1ps
package cell_form_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PULSE = 3'd1,
    ST_GAP   = 3'd2,
    ST_REQ   = 3'd3,
    ST_WAIT  = 3'd4
  } form_state_t;
endpackage

// File: rtl/cell_form_cfg.sv
`timescale 1ns/1ps
module cell_form_cfg #(
  parameter int RES_W  = 24,
  parameter int CODE_W = 8,
  parameter int WID_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RES_W-1:0]  thresh_in,
  input  logic [CODE_W-1:0] vlast_in,
  input  logic [WID_W-1:0]  base_in,
  input  logic [IDX_W-1:0]  idx_in,
  output logic [RES_W-1:0]  thresh_q,
  output logic [CODE_W-1:0] vlast_q,
  output logic [WID_W-1:0]  base_q,
  output logic [IDX_W-1:0]  idx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thresh_q <= '0;
      vlast_q  <= '0;
      base_q   <= WID_W'(1);
      idx_q    <= '0;
    end else if (load) begin
      thresh_q <= thresh_in;
      vlast_q  <= vlast_in;
      base_q   <= base_in;
      idx_q    <= idx_in;
    end
  end
endmodule

// File: rtl/cell_form_step.sv
`timescale 1ns/1ps
module cell_form_step #(
  parameter int CODE_W   = 8,
  parameter int WID_W    = 16,
  parameter int CAP_MULT = 10,
  parameter int V_STEP   = 1,
  localparam int CAP_W   = WID_W + $clog2(CAP_MULT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              load,
  input  logic              advance,
  input  logic [CODE_W-1:0] vfirst_in,
  input  logic [CODE_W-1:0] vlast_in,
  input  logic [WID_W-1:0]  base_in,
  input  logic [CODE_W-1:0] vlast_q,
  input  logic [WID_W-1:0]  base_q,
  output logic [CODE_W-1:0] volt,
  output logic [CAP_W-1:0]  next_width,
  output logic              last
);
  logic [CAP_W-1:0]  width;
  logic [CAP_W-1:0]  base_ext;
  logic [CAP_W-1:0]  cap;
  logic [CAP_W:0]    dbl;
  logic [CODE_W:0]   vsum;
  logic [CODE_W-1:0] vnext;
  logic              at_cap;

  assign base_ext = CAP_W'(base_q);
  assign cap      = base_ext * CAP_W'(CAP_MULT);
  assign at_cap   = (width == cap);
  assign dbl      = {width, 1'b0};
  assign vsum     = {1'b0, volt} + (CODE_W+1)'(V_STEP);
  assign vnext    = (vsum > {1'b0, vlast_q}) ? vlast_q : vsum[CODE_W-1:0];
  assign last     = at_cap && (volt >= vlast_q);

  always_comb begin
    if (at_cap)
      next_width = base_ext;
    else if (dbl > {1'b0, cap})
      next_width = cap;
    else
      next_width = dbl[CAP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      volt  <= '0;
      width <= CAP_W'(1);
    end else if (load) begin
      volt  <= (vfirst_in > vlast_in) ? vlast_in : vfirst_in;
      width <= CAP_W'(base_in);
    end else if (advance) begin
      width <= next_width;
      if (at_cap) volt <= vnext;
    end
  end

  assert_code_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load) |-> (volt <= vlast_q));
  assert_width_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load) |-> (width <= cap && width >= base_ext));
endmodule

// File: rtl/cell_form_timer.sv
`timescale 1ns/1ps
module cell_form_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= len - CNT_W'(1);
    else if (run && cnt != '0)
      cnt <= cnt - CNT_W'(1);
  end

  assign done = (cnt == '0);

  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/cell_form_ctrl.sv
`timescale 1ns/1ps
module cell_form_ctrl
  import cell_form_pkg::*;
#(
  parameter int RES_W    = 24,
  parameter int CODE_W   = 8,
  parameter int WID_W    = 16,
  parameter int IDX_W    = 5,
  parameter int CAP_MULT = 10,
  parameter int V_STEP   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  cell_idx,
  input  logic [RES_W-1:0]  cfg_thresh,
  input  logic [CODE_W-1:0] cfg_v_first,
  input  logic [CODE_W-1:0] cfg_v_last,
  input  logic [WID_W-1:0]  cfg_base_width,
  output logic [CODE_W-1:0] pulse_code,
  output logic              pulse_en,
  output logic [IDX_W-1:0]  cell_sel,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [RES_W-1:0]  res_data,
  output logic              busy,
  output logic              form_pass,
  output logic              form_fail
);
  localparam int CAP_W = WID_W + $clog2(CAP_MULT + 1);

  form_state_t       state;
  logic              start_acc;
  logic              res_take;
  logic              below;
  logic              advance;
  logic              last;
  logic              tmr_done;
  logic              tmr_load;
  logic [CAP_W-1:0]  tmr_len;
  logic [CAP_W-1:0]  next_width;
  logic [WID_W-1:0]  base_eff;
  logic [RES_W-1:0]  thresh_q;
  logic [CODE_W-1:0] vlast_q;
  logic [WID_W-1:0]  base_q;

  assign base_eff  = (cfg_base_width == '0) ? WID_W'(1) : cfg_base_width;
  assign start_acc = (state == ST_IDLE) && start;
  assign res_take  = (state == ST_WAIT) && res_valid;
  assign below     = (res_data < thresh_q);
  assign advance   = res_take && !below && !last;
  assign tmr_load  = start_acc || advance;
  assign tmr_len   = start_acc ? CAP_W'(base_eff) : next_width;

  cell_form_cfg #(.RES_W(RES_W), .CODE_W(CODE_W), .WID_W(WID_W), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(start_acc),
    .thresh_in(cfg_thresh), .vlast_in(cfg_v_last), .base_in(base_eff), .idx_in(cell_idx),
    .thresh_q(thresh_q), .vlast_q(vlast_q), .base_q(base_q), .idx_q(cell_sel)
  );

  cell_form_step #(.CODE_W(CODE_W), .WID_W(WID_W), .CAP_MULT(CAP_MULT), .V_STEP(V_STEP)) u_step (
    .clk(clk), .rst_n(rst_n), .active(busy), .load(start_acc), .advance(advance),
    .vfirst_in(cfg_v_first), .vlast_in(cfg_v_last), .base_in(base_eff),
    .vlast_q(vlast_q), .base_q(base_q),
    .volt(pulse_code), .next_width(next_width), .last(last)
  );

  cell_form_timer #(.CNT_W(CAP_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len),
    .run(state == ST_PULSE), .done(tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      form_pass <= 1'b0;
      form_fail <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state     <= ST_PULSE;
          form_pass <= 1'b0;
          form_fail <= 1'b0;
        end
        ST_PULSE: if (tmr_done) state <= ST_GAP;
        ST_GAP:   state <= ST_REQ;
        ST_REQ:   if (rd_ready) state <= ST_WAIT;
        ST_WAIT:  if (res_valid) begin
          if (below) begin
            form_pass <= 1'b1;
            state     <= ST_IDLE;
          end else if (last) begin
            form_fail <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            state <= ST_PULSE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pulse_en  = (state == ST_PULSE);
  assign rd_valid  = (state == ST_REQ);
  assign res_ready = (state == ST_WAIT);
  assign busy      = (state != ST_IDLE);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!busy && !pulse_en && !rd_valid && !form_pass && !form_fail));
  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  assert_code_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_en && $past(pulse_en)) |-> $stable(pulse_code));
  assert_req_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> !$past(pulse_en));
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);
  assert_res_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_ready && pulse_en));
  assert_pulse_after_res_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_en) |-> ($past(res_ready && res_valid) || $past(!busy)));
  assert_one_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(form_pass && form_fail));
  assert_verdict_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (form_pass || form_fail) |-> !busy);
endmodule

// File: tb/cell_form_ctrl_test.sv
`timescale 1ns/1ps
module cell_form_ctrl_test;
  localparam int RES_W = 24, CODE_W = 8, WID_W = 16, IDX_W = 5, CAP_MULT = 10, V_STEP = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [IDX_W-1:0]  cell_idx = '0;
  logic [RES_W-1:0]  cfg_thresh = '0;
  logic [CODE_W-1:0] cfg_v_first = '0;
  logic [CODE_W-1:0] cfg_v_last = '0;
  logic [WID_W-1:0]  cfg_base_width = '0;
  logic [CODE_W-1:0] pulse_code;
  logic pulse_en, rd_valid, res_ready, busy, form_pass, form_fail;
  logic rd_ready = 1'b0;
  logic res_valid = 1'b0;
  logic [RES_W-1:0] res_data = '0;
  logic [IDX_W-1:0] cell_sel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cell_form_ctrl #(.RES_W(RES_W), .CODE_W(CODE_W), .WID_W(WID_W), .IDX_W(IDX_W),
                   .CAP_MULT(CAP_MULT), .V_STEP(V_STEP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cell_idx(cell_idx),
    .cfg_thresh(cfg_thresh), .cfg_v_first(cfg_v_first), .cfg_v_last(cfg_v_last),
    .cfg_base_width(cfg_base_width), .pulse_code(pulse_code), .pulse_en(pulse_en),
    .cell_sel(cell_sel), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .busy(busy), .form_pass(form_pass), .form_fail(form_fail)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int widths_per_level(input int base);
    int w = base, n = 1;
    while (w < base * CAP_MULT) begin
      w = (2 * w > base * CAP_MULT) ? base * CAP_MULT : 2 * w;
      n++;
    end
    return n;
  endfunction

  function automatic int exp_width(input int base, input int j);
    int w = base;
    for (int p = 0; p < j % widths_per_level(base); p++)
      w = (2 * w > base * CAP_MULT) ? base * CAP_MULT : 2 * w;
    return w;
  endfunction

  // One forming run; pass_at = index of the passing read (-1: never)
  task automatic run(input int vf, input int vl, input int base_cfg, input int pass_at,
                     input int stall, input bit poke_busy, input int idx);
    int base = (base_cfg == 0) ? 1 : base_cfg;
    int nw = widths_per_level(base);
    int v0 = (vf > vl) ? vl : vf;
    int total = nw * (vl - v0 + 1);
    int thr = 1000 + idx;
    @(negedge clk);
    cfg_v_first = CODE_W'(vf); cfg_v_last = CODE_W'(vl);
    cfg_base_width = WID_W'(base_cfg); cfg_thresh = RES_W'(thr); cell_idx = IDX_W'(idx);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    check(form_pass == 0 && form_fail == 0, "R10 verdict cleared", int'(form_pass), 0);
    check(cell_sel == IDX_W'(idx), "R2 cell index", int'(cell_sel), idx);
    for (int j = 0; j < total; j++) begin
      int cnt = 0;
      int vexp = v0 + (j / nw) * V_STEP;
      if (vexp > vl) vexp = vl;
      while (!pulse_en) @(negedge clk);
      while (pulse_en) begin
        check(pulse_code == CODE_W'(vexp), "R4/R5 pulse code", int'(pulse_code), vexp);
        check(rd_valid == 0, "R6 no request in pulse", int'(rd_valid), 0);
        if (poke_busy && j == 1 && cnt == 0) begin
          start = 1'b1; cfg_v_last = CODE_W'(vl + 3); cfg_base_width = WID_W'(base + 1);
          cfg_thresh = '1;
        end else start = 1'b0;
        cnt++;
        @(negedge clk);
      end
      start = 1'b0;
      check(cnt == exp_width(base, j), "R3/R5 pulse width", cnt, exp_width(base, j));
      check(rd_valid == 0, "R6 gap cycle", int'(rd_valid), 0);
      @(negedge clk);
      check(rd_valid == 1, "R6 request after gap", int'(rd_valid), 1);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check(rd_valid == 1 && res_ready == 0, "R6 request held", int'(rd_valid), 1);
      end
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      check(res_ready == 1 && pulse_en == 0, "R7 result window", int'(res_ready), 1);
      if (stall > 1) begin
        @(negedge clk);
        check(res_ready == 1 && pulse_en == 0, "R7 waits for result", int'(pulse_en), 0);
      end
      res_valid = 1'b1;
      res_data = (j == pass_at) ? RES_W'(thr - 1) : ((j % 2 == 1) ? RES_W'(thr) : RES_W'(thr + 7));
      @(negedge clk);
      res_valid = 1'b0;
      if (j == pass_at) begin
        check(form_pass == 1 && form_fail == 0 && busy == 0, "R8 pass verdict", int'(form_pass), 1);
        break;
      end else if (j == total - 1) begin
        check(form_fail == 1 && form_pass == 0 && busy == 0, "R9 fail verdict", int'(form_fail), 1);
      end else begin
        check(busy == 1 && form_pass == 0, "R8 equal or above keeps going", int'(form_pass), 0);
      end
    end
    repeat (3) @(negedge clk);
    check(busy == 0 && pulse_en == 0, "R10 verdict held idle", int'(busy), 0);
    check((form_pass ^ form_fail) == 1, "R10 one verdict", int'(form_pass) + int'(form_fail), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && pulse_en == 0 && rd_valid == 0 && res_ready == 0 &&
          form_pass == 0 && form_fail == 0, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && form_pass == 0 && form_fail == 0, "R1 idle after reset", int'(busy), 0);
    // Config A: codes 3..6, base 2 -> widths 2,4,8,16,20; 20 pulses
    for (int k = -1; k < 20; k++) run(3, 6, 2, k, (k + 2) % 4, (k == 5), (k + 1) % 32);
    // Config B: single level, base 0 treated as 1 -> widths 1,2,4,8,10
    for (int k = -1; k < 5; k++) run(7, 7, 0, k, k + 1, 1'b0, 9);
    // First code above upper code: clamped start
    run(9, 4, 1, -1, 0, 1'b1, 3);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not end actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule